// File: doc/BRIEF.md
# Configurable-Framing Asynchronous Serial Transmitter

This block turns a parallel word into one asynchronous serial frame on a single output line. A word is offered with a valid/ready handshake. Once it is taken, the line drops to a low start bit. The data bits follow, lowest bit first, then an optional parity bit, then one or two high stop bits. After the frame the line is held high until the next word arrives.

The frame shape is chosen at run time through configuration inputs: the word length (full width or one bit shorter), one of five parity modes, and one or two stop bits. The bit period is given as a count of clock cycles. All of these are captured in the cycle the word is accepted, so they may change freely while a frame is on the line. The default 18-bit divider holds the 104167 cycles that a 1200 baud bit needs from a 125 MHz clock.

Top module: `serial_frame_tx`

## Requirements
- R1: During and right after reset, `tx_line` is 1 and `in_ready` is 1.
- R2: A word is taken only at a clock edge where `in_valid` and `in_ready` are both 1. In the next cycle `tx_line` is 0 (the start bit) and `in_ready` is 0. `in_valid` and `in_data` have no effect while `in_ready` is 0.
- R3: `in_ready` stays 0 from the start bit until the last stop bit has lasted its full period. It is 1 again in the cycle right after that.
- R4: Every bit of the frame is held on `tx_line` for exactly `cfg_bit_cycles` clock cycles. A value of 0 is treated as 1. Data bits are sent starting with bit 0, directly after the start bit.
- R5: With `cfg_word_full`=1 all DATA_W data bits are sent. With 0, only bits 0 to DATA_W-2 are sent and the top bit of `in_data` is ignored.
- R6: `cfg_parity` encoding: 0 none, 1 even, 2 odd, 3 mark (always 1), 4 space (always 0), 5 to 7 none. When parity is present, it takes the slot right after the last data bit.
- R7: Even parity makes the number of 1s across the sent data bits and the parity bit even. Odd parity makes it odd. Only the data bits actually sent are counted.
- R8: `cfg_two_stop`=1 sends two stop bits and 0 sends one. Stop bits are always 1.
- R9: The configuration inputs and `cfg_bit_cycles` are captured when the word is accepted. Changing them during a frame does not alter that frame.
- R10: Whenever no frame is in progress (`in_ready`=1), `tx_line` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Transmitter can take a word |
| in_data | input | DATA_W | Word to send, bit 0 first |
| cfg_word_full | input | 1 | 1: DATA_W data bits, 0: DATA_W-1 data bits |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_bit_cycles | input | DIV_W | Clock cycles per bit |
| tx_line | output | 1 | Serial output, idles high |

## Verification
Two events can fall in the same cycle. One is a word being offered. The other is the final cycle of a stop bit, which is the edge where the transmitter goes idle. The bench raises `in_valid` while a frame is still running and holds it there, and it also sends frames back to back with a one-cycle divider. A correct design takes the word only after `in_ready` has been seen high, and does not take it at the closing edge itself. This is judged by a behavioural model that queues the expected line level for every cycle and compares the line and `in_ready` on every clock. The same held-valid stimulus, with different data while busy, shows that words offered during a frame are ignored.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  // Parity slot present for codes 1..4 only (R6)
  function automatic logic parity_used(logic [2:0] mode);
    return (mode >= 3'd1) && (mode <= 3'd4);
  endfunction

  // Number of bit slots in one frame
  function automatic int unsigned slot_count(int unsigned word_bits,
                                             logic [2:0] mode,
                                             logic two_stop);
    return 1 + word_bits + (parity_used(mode) ? 1 : 0) + (two_stop ? 2 : 1);
  endfunction

endpackage

// File: rtl/sft_frame_builder.sv
module sft_frame_builder
  import sft_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int SLOT_W  = 4
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               word_full,
  input  logic [2:0]         mode,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [SLOT_W-1:0]  slots
);

  logic [DATA_W-1:0] sent_bits;
  logic              par_bit;
  int unsigned       word_bits;

  // Parity over the bits that go on the line only (R7)
  function automatic logic parity_of(logic [DATA_W-1:0] bits, logic [2:0] m);
    logic odd_ones;
    odd_ones = ^bits;
    case (m)
      PAR_EVEN:  return odd_ones;
      PAR_ODD:   return ~odd_ones;
      PAR_MARK:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  always_comb begin
    sent_bits = data;
    if (!word_full) sent_bits[DATA_W-1] = 1'b0;
    word_bits = word_full ? DATA_W : DATA_W - 1;
    par_bit   = parity_of(sent_bits, mode);

    frame    = '1;              // unused upper slots and stop bits are mark
    frame[0] = 1'b0;            // start bit
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(word_bits)) frame[i+1] = sent_bits[i];
    end
    if (parity_used(mode)) frame[word_bits+1] = par_bit;
    slots = SLOT_W'(slot_count(word_bits, mode, two_stop));
  end

endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int DIV_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             bit_end
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_in == '0) ? DIV_W'(1) : div_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt   <= '0;
    end else if (load) begin
      div_q <= div_eff;
      cnt   <= div_eff - DIV_W'(1);
    end else if (run) begin
      if (cnt == '0) cnt <= div_q - DIV_W'(1);
      else           cnt <= cnt - DIV_W'(1);
    end
  end

  assign bit_end = run && (cnt == '0);

  // R4: count never exceeds the captured period
  p_count_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < div_q));

  // R9: captured period is held for the whole frame
  p_div_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(div_q));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cfg_word_full,
  input  logic [2:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic [DIV_W-1:0]  cfg_bit_cycles,
  output logic              tx_line
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int SLOT_W  = $clog2(FRAME_W + 1);

  logic               busy;
  logic               accept;
  logic               bit_end;
  logic [FRAME_W-1:0] frame_new;
  logic [SLOT_W-1:0]  slots_new;
  logic [FRAME_W-1:0] frame_sr;
  logic [SLOT_W-1:0]  slots_left;

  assign accept   = in_valid && in_ready;
  assign in_ready = !busy;

  sft_frame_builder #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .SLOT_W (SLOT_W)
  ) u_builder (
    .data     (in_data),
    .word_full(cfg_word_full),
    .mode     (cfg_parity),
    .two_stop (cfg_two_stop),
    .frame    (frame_new),
    .slots    (slots_new)
  );

  sft_bit_timer #(
    .DIV_W(DIV_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .div_in (cfg_bit_cycles),
    .run    (busy),
    .bit_end(bit_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      tx_line    <= 1'b1;
      frame_sr   <= '1;
      slots_left <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      tx_line    <= frame_new[0];
      frame_sr   <= {1'b1, frame_new[FRAME_W-1:1]};
      slots_left <= slots_new;
    end else if (busy && bit_end) begin
      if (slots_left == SLOT_W'(1)) begin
        busy    <= 1'b0;
        tx_line <= 1'b1;
      end else begin
        tx_line    <= frame_sr[0];
        frame_sr   <= {1'b1, frame_sr[FRAME_W-1:1]};
        slots_left <= slots_left - SLOT_W'(1);
      end
    end
  end

  // R2: an accepted word starts with a space start bit and drops ready
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!tx_line && !in_ready));

  // R4: line only moves at a bit boundary
  p_hold_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end && !accept) |=> $stable(tx_line));

  // R3: ready is low only while slots remain
  p_ready_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slots_left != '0));

  // R8: the final slot of every frame is a mark stop bit
  p_last_stop_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_end && slots_left == SLOT_W'(1)) |-> tx_line);

  // R10: idle line is mark
  p_idle_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_line);

endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;

  localparam int DATA_W = 8;
  localparam int DIV_W  = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              cfg_word_full = 1'b1;
  logic [2:0]        cfg_parity = 3'd0;
  logic              cfg_two_stop = 1'b0;
  logic [DIV_W-1:0]  cfg_bit_cycles = DIV_W'(4);
  logic              tx_line;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag_override = "";

  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  serial_frame_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_word_full(cfg_word_full), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_bit_cycles(cfg_bit_cycles), .tx_line(tx_line)
  );

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // Behavioural model: expand one accepted word into per-cycle line levels
  task automatic model_push(logic [DATA_W-1:0] d, logic full, logic [2:0] par,
                            logic two, int div);
    int nb;
    int ones;
    int n;
    bit slot_v[$];
    string slot_t[$];
    nb = full ? DATA_W : DATA_W - 1;
    n = (div == 0) ? 1 : div;
    ones = 0;
    slot_v.push_back(1'b0); slot_t.push_back("R2");
    for (int i = 0; i < nb; i++) begin
      slot_v.push_back(d[i]);
      slot_t.push_back(full ? "R4" : "R5");
      if (d[i]) ones++;
    end
    case (par)
      3'd1: begin slot_v.push_back((ones % 2) == 1); slot_t.push_back("R7"); end
      3'd2: begin slot_v.push_back((ones % 2) == 0); slot_t.push_back("R7"); end
      3'd3: begin slot_v.push_back(1'b1); slot_t.push_back("R6"); end
      3'd4: begin slot_v.push_back(1'b0); slot_t.push_back("R6"); end
      default: ;
    endcase
    slot_v.push_back(1'b1); slot_t.push_back("R8");
    if (two) begin slot_v.push_back(1'b1); slot_t.push_back("R8"); end
    foreach (slot_v[k]) begin
      for (int c = 0; c < n; c++) begin
        exp_q.push_back(slot_v[k]);
        tag_q.push_back(tag_override != "" ? tag_override : slot_t[k]);
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      tag_q.delete();
    end else begin
      bit idle_before;
      idle_before = (exp_q.size() == 0);
      if (!idle_before) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (idle_before && in_valid)
        model_push(in_data, cfg_word_full, cfg_parity, cfg_two_stop, int'(cfg_bit_cycles));
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (exp_q.size() != 0) begin
        check(tag_q[0], "tx_line", int'(tx_line), int'(exp_q[0]));
        check("R3", "in_ready busy", int'(in_ready), 0);
      end else begin
        check("R10", "tx_line idle", int'(tx_line), 1);
        check("R3", "in_ready idle", int'(in_ready), 1);
      end
    end
  end

  task automatic setup(logic full, logic [2:0] par, logic two, int div);
    cfg_word_full  = full;
    cfg_parity     = par;
    cfg_two_stop   = two;
    cfg_bit_cycles = DIV_W'(div);
  endtask

  task automatic send(logic [DATA_W-1:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "tx_line in reset", int'(tx_line), 1);
    check("R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "tx_line after reset", int'(tx_line), 1);
    check("R1", "in_ready after reset", int'(in_ready), 1);

    // R4: plain 8-bit, no parity, one stop
    setup(1'b1, 3'd0, 1'b0, 4);
    send(8'hA5); wait_idle();
    send(8'h3C); wait_idle();

    // R7: even and odd parity, two stop bits (R8)
    setup(1'b1, 3'd1, 1'b0, 3);
    send(8'h07); wait_idle();
    send(8'h00); wait_idle();
    setup(1'b1, 3'd2, 1'b1, 5);
    send(8'h07); wait_idle();
    send(8'hFF); wait_idle();

    // R5/R7: same low bits, 7-bit and 8-bit word give different parity
    setup(1'b0, 3'd1, 1'b0, 2);
    send(8'h80); wait_idle();
    setup(1'b1, 3'd1, 1'b0, 2);
    send(8'h80); wait_idle();
    setup(1'b0, 3'd2, 1'b1, 3);
    send(8'hD5); wait_idle();

    // R6: mark, space, reserved code treated as none
    setup(1'b1, 3'd3, 1'b0, 3);
    send(8'h00); wait_idle();
    setup(1'b1, 3'd4, 1'b1, 3);
    send(8'hFF); wait_idle();
    setup(1'b1, 3'd6, 1'b0, 3);
    send(8'h5A); wait_idle();

    // R4: divider 0 acts as 1; back-to-back with divider 1 (R2/R3 edge)
    setup(1'b1, 3'd1, 1'b0, 0);
    send(8'h96); wait_idle();
    setup(1'b1, 3'd2, 1'b0, 1);
    @(negedge clk);
    in_data = 8'h69; in_valid = 1'b1;
    repeat (40) @(negedge clk);   // held valid across several frame ends
    in_valid = 1'b0;
    wait_idle();

    // R9: configuration changed mid-frame has no effect
    setup(1'b1, 3'd1, 1'b1, 6);
    tag_override = "R9";
    send(8'hC3);
    setup(1'b0, 3'd3, 1'b0, 2);
    repeat (20) @(negedge clk);
    tag_override = "";
    wait_idle();

    // R2: valid with other data while busy is ignored
    setup(1'b1, 3'd0, 1'b0, 8);
    send(8'h11);
    in_data = 8'hEE; in_valid = 1'b1;
    repeat (30) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R4: long bit period
    setup(1'b1, 3'd2, 1'b1, 1000);
    send(8'h4B); wait_idle();

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got %0d expected 0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule